// File: doc/BRIEF.md
# UART Baud Generator with Fractional Prescaler

This block produces the timing enables that a UART's serial engines run on. A reference clock first passes a prescaler whose ratio is an integer plus a number of eighths, then a 16-bit divisor, and finally a counter that groups a programmable number of sample ticks into one bit period. The transmit and receive engines use the resulting sample-tick enable for oversampling and the bit-tick enable to step from bit to bit.

A 1x transmit clock, high for the first half of every bit period, is also driven for isochronous links. The divisor is loaded one byte at a time, and the sample-count register is written through the same byte bus. A channel-local soft reset returns the counters and both registers to their cleared state. New divisor or sample-count values are picked up at the next counter reload, so a running tick is never cut short.

Top module: `uart_baud_gen`

## Requirements
- R1: While rst_ni is low, smp_tick_o, bit_tick_o and tx_clk_o are 0 and smp_cfg_o reads 0x00.
- R2: With integer part N (presc_int_i, 0 treated as 1) and fraction F (presc_frac_i, in eighths), the prescaler spends N or N+1 reference cycles per output pulse, and any 8 consecutive pulses take exactly 8N+F cycles.
- R3: The divisor is 16 bits: a write with div_lo_we_i loads bits 7:0 and one with div_hi_we_i loads bits 15:8 from cfg_wdata_i. smp_tick_o pulses once every D prescaler pulses, a divisor of 0 acting as 1.
- R4: The number of sample ticks per bit comes from bits 3:0 of the sample-count register: code 0 means 16, codes 1 to 3 mean 4, and codes 4 to 15 mean that many.
- R5: Bits 7:4 of the value written with smp_we_i are discarded; smp_cfg_o returns bits 3:0 of the register with bits 7:4 reading 0.
- R6: bit_tick_o pulses only in a cycle in which smp_tick_o also pulses, once every S sample ticks, S being the count from R4.
- R7: tx_clk_o rises in the cycle after a bit tick and stays high for S minus floor(S/2) sample ticks of each bit period, then stays low for the rest.
- R8: A pulse on soft_rst_i clears the counters, the divisor and the sample-count register; in the following cycle no tick is issued, tx_clk_o is 0 and smp_cfg_o reads 0x00.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous channel reset |
| presc_int_i | input | 5 | Prescaler integer part |
| presc_frac_i | input | 3 | Prescaler fraction in eighths |
| div_lo_we_i | input | 1 | Load divisor low byte |
| div_hi_we_i | input | 1 | Load divisor high byte |
| smp_we_i | input | 1 | Load sample-count register |
| cfg_wdata_i | input | 8 | Write data for the register loads |
| smp_cfg_o | output | 8 | Sample-count register readback |
| smp_tick_o | output | 1 | Oversampling enable, one cycle wide |
| bit_tick_o | output | 1 | Bit-period enable, one cycle wide |
| tx_clk_o | output | 1 | 1x transmit clock |

## Verification
The bit tick and the sample tick always fall in the same cycle at the end of each bit, and the tx clock rise is launched from that same cycle. The scoreboard counts, per bit period, the cycles, the sample ticks and the sample ticks seen with tx_clk_o high, taking the window from just after one bit tick up to and including the next, so a bit tick that fired without its sample tick, or one sample early, shows as a wrong count of S or of S minus floor(S/2). Each configuration uses ratios whose fractional parts cancel within one bit, making every bit period exactly predictable from the requirement formulas.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int unsigned SMP_W     = 4;
  localparam int unsigned BIT_CNT_W = SMP_W + 1;
  localparam int unsigned SMP_MIN   = 4;

  // code 0 -> full 2**SMP_W, small codes clamped to the usable minimum
  function automatic logic [BIT_CNT_W-1:0] samples_per_bit(input logic [SMP_W-1:0] code);
    if (code == '0)                 return BIT_CNT_W'(1 << SMP_W);
    else if (code < SMP_W'(SMP_MIN)) return BIT_CNT_W'(SMP_MIN);
    else                             return BIT_CNT_W'(code);
  endfunction
endpackage

// File: rtl/baud_presc.sv
module baud_presc #(
  parameter int unsigned INT_W  = 5,
  parameter int unsigned FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);
  logic [INT_W-1:0]  cnt_q, int_eff, reload;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic              live_q;

  assign int_eff = (int_i == '0) ? INT_W'(1) : int_i;
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_i};
  // carry out of the fraction stretches the next period by one cycle
  assign reload  = int_eff - INT_W'(1) + INT_W'(acc_sum[FRAC_W]);
  assign tick_o  = live_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      live_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (tick_o) begin
        cnt_q <= reload;
        acc_q <= acc_sum[FRAC_W-1:0];
      end else if (live_q) begin
        cnt_q <= cnt_q - INT_W'(1);
      end
    end
  end
endmodule

// File: rtl/baud_cnt.sv
module baud_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic         tick_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);
  assign cnt_o  = cnt_q;

  // reload value is sampled only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - W'(1);
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int unsigned INT_W  = 5,
  parameter int unsigned FRAC_W = 3,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [INT_W-1:0]  presc_int_i,
  input  logic [FRAC_W-1:0] presc_frac_i,
  input  logic              div_lo_we_i,
  input  logic              div_hi_we_i,
  input  logic              smp_we_i,
  input  logic [BYTE_W-1:0] cfg_wdata_i,
  output logic [BYTE_W-1:0] smp_cfg_o,
  output logic              smp_tick_o,
  output logic              bit_tick_o,
  output logic              tx_clk_o
);
  localparam int unsigned DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0]     div_q, div_reload, div_cnt;
  logic [SMP_W-1:0]     smp_q;
  logic [BIT_CNT_W-1:0] n_smp, bit_reload, bit_cnt, half;
  logic                 presc_tick, tx_clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      smp_q <= '0;
    end else if (soft_rst_i) begin
      div_q <= '0;
      smp_q <= '0;
    end else begin
      if (div_lo_we_i) div_q[BYTE_W-1:0]     <= cfg_wdata_i;
      if (div_hi_we_i) div_q[DIV_W-1:BYTE_W] <= cfg_wdata_i;
      if (smp_we_i)    smp_q                 <= cfg_wdata_i[SMP_W-1:0];
    end
  end

  assign smp_cfg_o  = BYTE_W'(smp_q);
  assign div_reload = (div_q == '0) ? '0 : div_q - DIV_W'(1);
  assign n_smp      = samples_per_bit(smp_q);
  assign bit_reload = n_smp - BIT_CNT_W'(1);
  assign half       = n_smp >> 1;

  baud_presc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (soft_rst_i),
    .int_i  (presc_int_i),
    .frac_i (presc_frac_i),
    .tick_o (presc_tick)
  );

  baud_cnt #(.W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst_i),
    .en_i     (presc_tick),
    .reload_i (div_reload),
    .tick_o   (smp_tick_o),
    .cnt_o    (div_cnt)
  );

  baud_cnt #(.W(BIT_CNT_W)) u_bit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst_i),
    .en_i     (smp_tick_o),
    .reload_i (bit_reload),
    .tick_o   (bit_tick_o),
    .cnt_o    (bit_cnt)
  );

  // high from the bit tick until the count reaches the half point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tx_clk_q <= 1'b0;
    else if (soft_rst_i)                  tx_clk_q <= 1'b0;
    else if (bit_tick_o)                  tx_clk_q <= 1'b1;
    else if (smp_tick_o && bit_cnt <= half) tx_clk_q <= 1'b0;
  end

  assign tx_clk_o = tx_clk_q;

  logic unused_div_cnt;
  assign unused_div_cnt = ^div_cnt;
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
  parameter int unsigned INT_W = 5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       presc_tick_i,
  input logic       smp_tick_i,
  input logic       bit_tick_i,
  input logic       tx_clk_i,
  input logic [7:0] smp_cfg_i
);
  localparam int unsigned GAP_W   = INT_W + 1;
  localparam int unsigned GAP_MAX = (1 << INT_W) - 1;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        gap_q <= '0;
    else if (soft_rst_i || presc_tick_i) gap_q <= '0;
    else if (gap_q != '1)                gap_q <= gap_q + GAP_W'(1);
  end

  a_r2_presc_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_W'(GAP_MAX));

  a_r3_smp_on_presc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_tick_i |-> presc_tick_i);

  a_r6_bit_on_smp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_i |-> smp_tick_i);

  a_r7_tx_rise_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_clk_i) |-> $past(bit_tick_i));

  a_r8_soft_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!smp_tick_i && !bit_tick_i && !tx_clk_i && smp_cfg_i == 8'h00));
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.INT_W(INT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .presc_tick_i (presc_tick),
  .smp_tick_i   (smp_tick_o),
  .bit_tick_i   (bit_tick_o),
  .tx_clk_i     (tx_clk_o),
  .smp_cfg_i    (smp_cfg_o)
);

// File: tb/tb_uart_baud_gen.sv
`timescale 1ns/1ps
module tb_uart_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic [4:0] p_int = 5'd1;
  logic [2:0] p_frac = 3'd0;
  logic       div_lo_we = 1'b0, div_hi_we = 1'b0, smp_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] smp_cfg;
  logic       smp_tick, bit_tick, tx_clk;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_baud_gen dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .soft_rst_i   (soft_rst),
    .presc_int_i  (p_int),
    .presc_frac_i (p_frac),
    .div_lo_we_i  (div_lo_we),
    .div_hi_we_i  (div_hi_we),
    .smp_we_i     (smp_we),
    .cfg_wdata_i  (wdata),
    .smp_cfg_o    (smp_cfg),
    .smp_tick_o   (smp_tick),
    .bit_tick_o   (bit_tick),
    .tx_clk_o     (tx_clk)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard
  int    exp_cyc_q[$];
  int    exp_smp_q[$];
  int    exp_hi_q[$];
  string exp_tag_q[$];
  int    skip = 0;
  int    cyc_cnt = 0, smp_cnt = 0, hi_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc_cnt++;
      if (smp_tick) begin
        smp_cnt++;
        if (tx_clk) hi_cnt++;
      end
      if (bit_tick) begin
        if (skip > 0) skip--;
        else if (exp_cyc_q.size() > 0) begin
          chk(exp_tag_q.pop_front(), cyc_cnt, exp_cyc_q.pop_front());
          chk("R6", smp_cnt, exp_smp_q.pop_front());
          chk("R7", hi_cnt, exp_hi_q.pop_front());
        end
        cyc_cnt = 0;
        smp_cnt = 0;
        hi_cnt  = 0;
      end
    end
  end

  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wdata     = d;
    div_lo_we = (sel == 0);
    div_hi_we = (sel == 1);
    smp_we    = (sel == 2);
    @(negedge clk);
    div_lo_we = 1'b0;
    div_hi_we = 1'b0;
    smp_we    = 1'b0;
  endtask

  task automatic run_cfg(input int n_int, input int frac, input int div, input int smp,
                         input bit do_wr, input int nbits, input string tag);
    int ne, de, ie, ecyc;
    @(negedge clk);
    soft_rst = 1'b1;
    p_int    = 5'(n_int);
    p_frac   = 3'(frac);
    @(negedge clk);
    soft_rst = 1'b0;
    if (do_wr) begin
      wr(0, 8'(div));
      wr(1, 8'(div >> 8));
      wr(2, 8'(smp));
    end
    ne   = ((smp & 15) == 0) ? 16 : (((smp & 15) < 4) ? 4 : (smp & 15));
    de   = (div == 0) ? 1 : div;
    ie   = (n_int == 0) ? 1 : n_int;
    ecyc = ne * de * (8 * ie + frac) / 8;
    skip = 2;
    for (int i = 0; i < nbits; i++) begin
      exp_cyc_q.push_back(ecyc);
      exp_smp_q.push_back(ne);
      exp_hi_q.push_back(ne - ne / 2);
      exp_tag_q.push_back(tag);
    end
    while (exp_cyc_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", int'(smp_tick), 0);
    chk("R1", int'(bit_tick), 0);
    chk("R1", int'(tx_clk), 0);
    chk("R1", int'(smp_cfg), 0);
    rst_n = 1'b1;

    run_cfg(1, 0, 1, 8'h00, 1'b1, 3, "R4");     // code 0 -> 16 samples
    run_cfg(2, 4, 1, 8'h00, 1'b1, 3, "R2");     // ratio 2.5
    run_cfg(3, 1, 3, 8'h08, 1'b1, 3, "R2");     // ratio 3.125, divisor 3
    run_cfg(31, 7, 1, 8'h08, 1'b1, 2, "R2");    // maximum ratio 31.875
    run_cfg(0, 0, 1, 8'h04, 1'b1, 3, "R2");     // integer 0 acts as 1
    run_cfg(1, 0, 0, 8'h0D, 1'b1, 3, "R3");     // divisor 0 acts as 1, 13 samples
    run_cfg(1, 0, 2, 8'hF2, 1'b1, 3, "R4");     // code 2 -> 4 samples
    @(negedge clk);
    chk("R5", int'(smp_cfg), 8'h02);            // upper nibble discarded
    run_cfg(1, 0, 16'h0102, 8'h04, 1'b1, 2, "R3"); // both divisor bytes

    // R8 soft reset clears the registers
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R8", int'(smp_cfg), 0);
    chk("R8", int'(tx_clk), 0);
    run_cfg(1, 0, 0, 8'h00, 1'b0, 3, "R8");     // cleared divisor and count

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule